// File: doc/BRIEF.md
# Packed-BCD Subtraction Adjust Unit

This unit corrects an 8-bit accumulator after a subtraction of two packed-BCD bytes, so that the result is again a valid two-digit packed-BCD value. It takes the accumulator, the incoming carry and the incoming auxiliary carry. It returns the adjusted accumulator, the new carry and the new auxiliary carry, together with sign, zero and parity flags computed from the final value. An overflow flag is passed straight through, so the policy for that undefined flag is set outside the unit.

Both correction decisions use the accumulator and carry as they were at the input. The high-digit test looks at the original value, not at the value left by the low-digit step. The carry out is the input carry ORed with the borrow of the low step. It is forced to 1 when the high step applies.

The parameter `REGISTERED` selects the variant. With 1, the unit takes a `valid_i` strobe, raises `valid_o` one clock later and holds its outputs between strobes. With 0, the unit is purely combinational and `valid_o` follows `valid_i`.

Top module: `bcd_sub_adjust`

## Requirements
- R1: The low correction applies when acc_i[3:0] is greater than 9 or af_i is 1. It subtracts 6 from the accumulator (mod 256) and sets af_o to 1. Otherwise the accumulator is unchanged by this step and af_o is 0.
- R2: When the low correction applies, the intermediate carry is cf_i OR the borrow out of the 8-bit subtraction of 6. The borrow is 1 exactly when acc_i < 6.
- R3: The high correction applies when the original acc_i is greater than 0x99 or the original cf_i is 1. It subtracts 0x60 (mod 256) from the value after the low step and drives cf_o to 1. The decision never depends on the low-step result.
- R4: When the high correction does not apply, cf_o equals the intermediate carry from R2. That carry is 0 if the low correction was skipped.
- R5: sf_o is bit 7 of the final accumulator. zf_o is 1 when the final accumulator is 0x00. pf_o is 1 when the final accumulator has an even number of set bits.
- R6: of_o equals of_i, registered alongside the result in the registered variant.
- R7: In the registered variant, valid_o is 1 exactly in the clock after a clock with valid_i 1. All outputs hold their values while valid_i is 0.
- R8: While rst_ni is low, the registered variant drives valid_o and every result output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (registered variant) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe |
| acc_i | input | 8 | Accumulator after the BCD subtraction |
| cf_i | input | 1 | Incoming carry |
| af_i | input | 1 | Incoming auxiliary carry |
| of_i | input | 1 | Overflow value to pass through |
| valid_o | output | 1 | Result strobe |
| acc_o | output | 8 | Adjusted accumulator |
| cf_o | output | 1 | New carry |
| af_o | output | 1 | New auxiliary carry |
| sf_o | output | 1 | Sign of result |
| zf_o | output | 1 | Result is zero |
| pf_o | output | 1 | Even parity of result |
| of_o | output | 1 | Passed-through overflow |

## Verification
The bench builds two instances: `u_dut` with REGISTERED=1 and `u_dut_comb` with REGISTERED=0. Both get the same sweep of all 256 accumulator values under the four carry and auxiliary-carry combinations. The registered instance runs back to back, and also with gaps that expose the one-clock latency and the hold behaviour. The combinational instance is compared in the same cycle. Hand-picked vectors pin down the cases where the original-value test and the borrow-driven carry give a different answer from an adjust that tests the partly corrected value, for example 0x00 with the auxiliary carry set.

// File: rtl/bcd_sub_adjust_pkg.sv
package bcd_sub_adjust_pkg;
  localparam int unsigned ACC_W   = 8;
  localparam int unsigned NIB_W   = ACC_W / 2;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [ACC_W-1:0] LOW_FIX   = ACC_W'(8'h06);
  localparam logic [ACC_W-1:0] HIGH_FIX  = ACC_W'(8'h60);
  localparam logic [ACC_W-1:0] HIGH_LIM  = ACC_W'(8'h99);

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic             cf;
    logic             af;
    logic             sf;
    logic             zf;
    logic             pf;
    logic             of;
  } adj_res_t;
endpackage

// File: rtl/bcd_sub_low_step.sv
module bcd_sub_low_step
  import bcd_sub_adjust_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic             cf_i,
  input  logic             af_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             cf_o,
  output logic             af_o
);
  logic [ACC_W:0] diff;
  logic           apply;

  assign apply = (acc_i[NIB_W-1:0] > DIGIT_MAX) | af_i;
  assign diff  = {1'b0, acc_i} - {1'b0, LOW_FIX};

  always_comb begin
    if (apply) begin
      acc_o = diff[ACC_W-1:0];
      cf_o  = cf_i | diff[ACC_W];
      af_o  = 1'b1;
    end else begin
      acc_o = acc_i;
      cf_o  = 1'b0;
      af_o  = 1'b0;
    end
  end

  always_comb begin
    if (!apply) p_low_idle_r1: assert (acc_o == acc_i && !cf_o);
    if (apply && acc_i < LOW_FIX) p_borrow_r2: assert (cf_o);
  end
endmodule

// File: rtl/bcd_sub_high_step.sv
module bcd_sub_high_step
  import bcd_sub_adjust_pkg::*;
(
  input  logic [ACC_W-1:0] orig_acc_i,
  input  logic             orig_cf_i,
  input  logic [ACC_W-1:0] mid_acc_i,
  input  logic             mid_cf_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             cf_o
);
  logic apply;
  assign apply = (orig_acc_i > HIGH_LIM) | orig_cf_i;

  always_comb begin
    if (apply) begin
      acc_o = mid_acc_i - HIGH_FIX;
      cf_o  = 1'b1;
    end else begin
      acc_o = mid_acc_i;
      cf_o  = mid_cf_i;
    end
  end

  always_comb begin
    if (orig_cf_i) p_cf_forced_r3: assert (cf_o);
    if (!apply) p_cf_kept_r4: assert (cf_o == mid_cf_i && acc_o == mid_acc_i);
  end
endmodule

// File: rtl/bcd_sub_flag_gen.sv
module bcd_sub_flag_gen
  import bcd_sub_adjust_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  output logic             sf_o,
  output logic             zf_o,
  output logic             pf_o
);
  assign sf_o = acc_i[ACC_W-1];
  assign zf_o = (acc_i == '0);
  assign pf_o = ~^acc_i;
endmodule

// File: rtl/bcd_sub_adjust.sv
module bcd_sub_adjust
  import bcd_sub_adjust_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             cf_i,
  input  logic             af_i,
  input  logic             of_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             cf_o,
  output logic             af_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic             pf_o,
  output logic             of_o
);
  logic [ACC_W-1:0] mid_acc;
  logic             mid_cf;
  adj_res_t         res;

  bcd_sub_low_step u_low (
    .acc_i (acc_i),
    .cf_i  (cf_i),
    .af_i  (af_i),
    .acc_o (mid_acc),
    .cf_o  (mid_cf),
    .af_o  (res.af)
  );

  bcd_sub_high_step u_high (
    .orig_acc_i (acc_i),
    .orig_cf_i  (cf_i),
    .mid_acc_i  (mid_acc),
    .mid_cf_i   (mid_cf),
    .acc_o      (res.acc),
    .cf_o       (res.cf)
  );

  bcd_sub_flag_gen u_flags (
    .acc_i (res.acc),
    .sf_o  (res.sf),
    .zf_o  (res.zf),
    .pf_o  (res.pf)
  );

  assign res.of = of_i;

  always_comb begin
    if (valid_i) begin
      p_af_cond_r1: assert (res.af == ((acc_i[NIB_W-1:0] > DIGIT_MAX) | af_i));
      if (acc_i > HIGH_LIM) p_high_orig_r3: assert (res.cf);
    end
  end

  adj_res_t out_q;
  logic     vld_q;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          out_q <= '0;
          vld_q <= 1'b0;
        end else begin
          vld_q <= valid_i;
          if (valid_i) out_q <= res;
        end
      end

      p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);
      p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);
      p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(acc_o) && $stable(cf_o) && $stable(af_o));
      p_of_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> of_o == $past(of_i));
    end else begin : g_comb
      always_comb begin
        out_q = res;
        vld_q = valid_i;
      end
    end
  endgenerate

  assign valid_o = vld_q;
  assign acc_o   = out_q.acc;
  assign cf_o    = out_q.cf;
  assign af_o    = out_q.af;
  assign sf_o    = out_q.sf;
  assign zf_o    = out_q.zf;
  assign pf_o    = out_q.pf;
  assign of_o    = out_q.of;
endmodule

// File: tb/bcd_sub_adjust_tb.sv
module bcd_sub_adjust_tb;
  typedef struct packed {
    logic [7:0] acc;
    logic cf, af, sf, zf, pf, of;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [7:0] acc = '0;
  logic cf = 1'b0, af = 1'b0, of = 1'b0;

  logic vr, vc;
  logic [7:0] accr, accc;
  logic cfr, afr, sfr, zfr, pfr, ofr;
  logic cfc, afc, sfc, zfc, pfc, ofc;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  exp_t q[$];
  exp_t last_exp;
  bit have_last = 1'b0;

  always #10 clk = ~clk;

  bcd_sub_adjust #(.REGISTERED(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .acc_i(acc), .cf_i(cf),
    .af_i(af), .of_i(of), .valid_o(vr), .acc_o(accr), .cf_o(cfr), .af_o(afr),
    .sf_o(sfr), .zf_o(zfr), .pf_o(pfr), .of_o(ofr));

  bcd_sub_adjust #(.REGISTERED(1'b0)) u_dut_comb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .acc_i(acc), .cf_i(cf),
    .af_i(af), .of_i(of), .valid_o(vc), .acc_o(accc), .cf_o(cfc), .af_o(afc),
    .sf_o(sfc), .zf_o(zfc), .pf_o(pfc), .of_o(ofc));

  function automatic exp_t model(logic [7:0] a, logic c, logic x, logic o);
    exp_t e;
    logic [7:0] t;
    logic c1;
    bit lo, hi;
    lo = (a[3:0] > 4'd9) || x;
    t  = lo ? a - 8'h06 : a;
    c1 = lo ? (c | (a < 8'h06)) : 1'b0;
    hi = (a > 8'h99) || c;
    e.acc = hi ? t - 8'h60 : t;
    e.cf  = hi ? 1'b1 : c1;
    e.af  = lo;
    e.sf  = e.acc[7];
    e.zf  = (e.acc == 8'h00);
    e.pf  = ~^e.acc;
    e.of  = o;
    return e;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(string who, logic [7:0] a, logic c, logic x, logic s,
                     logic z, logic p, logic o, exp_t e);
    chk({who, " R1/R3 acc"}, a, e.acc);
    chk({who, " R2/R4 cf"}, {7'd0, c}, {7'd0, e.cf});
    chk({who, " R1 af"}, {7'd0, x}, {7'd0, e.af});
    chk({who, " R5 flags"}, {5'd0, s, z, p}, {5'd0, e.sf, e.zf, e.pf});
    chk({who, " R6 of"}, {7'd0, o}, {7'd0, e.of});
  endtask

  // driver: apply at negedge, push expected, check comb variant in same cycle
  task automatic drive(logic [7:0] a, logic c, logic x, logic o);
    exp_t e;
    @(negedge clk);
    acc = a; cf = c; af = x; of = o; valid = 1'b1;
    e = model(a, c, x, o);
    q.push_back(e);
    #1;
    chk("R7 comb valid", {7'd0, vc}, 8'd1);
    cmp("comb", accc, cfc, afc, sfc, zfc, pfc, ofc, e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  // directed check against hand-computed values
  task automatic directed(string tag, logic [7:0] a, logic c, logic x,
                          logic [7:0] ea, logic ec, logic ex);
    exp_t e;
    e = model(a, c, x, 1'b0);
    chk({tag, " model acc"}, e.acc, ea);
    chk({tag, " model cf"}, {7'd0, e.cf}, {7'd0, ec});
    chk({tag, " model af"}, {7'd0, e.af}, {7'd0, ex});
    drive(a, c, x, 1'b0);
  endtask

  // monitor: pop and compare as the registered unit produces results
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (vr) begin
          if (q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R7 unexpected valid_o actual=1 expected=0");
          end else begin
            last_exp = q.pop_front();
            have_last = 1'b1;
            cmp("reg", accr, cfr, afr, sfr, zfr, pfr, ofr, last_exp);
          end
        end else if (have_last) begin
          chk("R7 hold acc", accr, last_exp.acc);
          chk("R7 hold flags", {2'd0, cfr, afr, sfr, zfr, pfr, ofr},
              {2'd0, last_exp.cf, last_exp.af, last_exp.sf, last_exp.zf,
               last_exp.pf, last_exp.of});
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid_o", {7'd0, vr}, 8'd0);
    chk("R8 reset acc_o", accr, 8'h00);
    chk("R8 reset flags", {1'b0, cfr, afr, sfr, zfr, pfr, ofr, 1'b0}, 8'd0);
    rst_n = 1'b1;
    idle(2);

    directed("R2 borrow 00/af", 8'h00, 1'b0, 1'b1, 8'hFA, 1'b1, 1'b1);
    directed("R1 low 10/af", 8'h10, 1'b0, 1'b1, 8'h0A, 1'b0, 1'b1);
    directed("R3 orig 9A", 8'h9A, 1'b0, 1'b0, 8'h34, 1'b1, 1'b1);
    directed("R4 none 99", 8'h99, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0);
    directed("R3 high A0", 8'hA0, 1'b0, 1'b0, 8'h40, 1'b1, 1'b0);
    directed("R3 cf 05", 8'h05, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0);
    directed("R5 zero 66", 8'h66, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    idle(3);

    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 256; a++) begin
        drive(8'(a), m[1], m[0], a[2] ^ m[0]);
        if (m == 2 && a % 17 == 0) idle(2);
      end
    end
    idle(4);
    chk("R7 queue drained", 8'(q.size()), 8'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule